// File: doc/BRIEF.md
# Trigger Endpoint Handshake and Number Checker

This block sits in a detector readout endpoint between the trigger network and the user's readout logic. A single-cycle trigger strobe arrives first; some time later the readout network delivers a 64-bit information word for that trigger. The block splits the word into trigger type, trigger number, random code and additional information. It holds these fields for the user logic behind a received flag, and keeps that flag high until the user hands back a busy-release together with a 32-bit error pattern.

A local 16-bit counter counts the strobes. When the information word arrives, the number it carries is compared with this count. If the two differ, bit 0 of the returned error pattern is set and the block releases the trigger on its own, so a lost or extra strobe cannot stall the endpoint. The counter can be cleared from a control-register bit. A strobe that comes while the previous trigger is still unreleased is counted, and it also sets a sticky violation flag.

Top module: `trig_endpoint`

## Requirements
- R1: The received flag rises one clock after `pkt_valid_i` is sampled high while the flag is low. The decoded outputs then show type = word[3:0], number = word[31:16], random code = word[39:32] and information = word[63:40].
- R2: While the received flag is high, the decoded outputs hold their values, and any further information word is ignored.
- R3: When `user_release_i` is sampled high while the flag is high, the flag falls one clock later. In that same cycle `rel_valid_o` pulses high for exactly one clock, and `rel_err_o` carries the `user_err_i` value sampled at the release edge. A release while the flag is low has no effect.
- R4: The strobe counter on `strobe_cnt_o` increments by one on each strobe and wraps from 0xFFFF to 0x0000.
- R5: The trigger number is compared for exact 16-bit equality with the strobe count, including a strobe in the same cycle. On a match, bit 0 of the returned pattern is the user's bit 0. On a mismatch, bit 0 is forced to 1 and ORed with the user pattern.
- R6: On a mismatch, the flag falls and `rel_valid_o` pulses one clock after the flag rose, with no user release.
- R7: `cnt_clear_i` sets the strobe counter to zero on the next clock and takes priority over a strobe in the same cycle.
- R8: A strobe that arrives while an earlier strobe has not yet been released still increments the counter. It also sets `proto_viol_o`, which stays high until reset.
- R9: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Synchronised single-cycle trigger strobe |
| pkt_valid_i | input | 1 | Information word valid |
| pkt_word_i | input | 64 | Trigger information word |
| cnt_clear_i | input | 1 | Control bit that clears the strobe counter |
| user_release_i | input | 1 | Busy-release from user logic |
| user_err_i | input | 32 | Error pattern from user logic |
| trg_seen_o | output | 1 | Trigger received, fields valid |
| trg_type_o | output | 4 | Trigger type |
| trg_num_o | output | 16 | Trigger number from the word |
| trg_rand_o | output | 8 | Random code |
| trg_info_o | output | 24 | Additional information |
| rel_valid_o | output | 1 | One-cycle release pulse toward the network |
| rel_err_o | output | 32 | Returned error pattern |
| strobe_cnt_o | output | 16 | Local strobe count |
| proto_viol_o | output | 1 | Sticky strobe-while-busy flag |

## Verification
Each result has a fixed latency. The received flag and the decoded fields register one edge after the word is accepted. The release pulse, the returned pattern and the falling flag register one edge after the user release, or one edge after the flag rose when the numbers mismatch. The counter and the violation flag update one edge after a strobe. The bench drives inputs just after the falling edge and samples at the following falling edge, so each check lands exactly one rising edge after its stimulus. A second sample one clock later confirms that the release pulse is single and that the flag stays high in the match cases.

// File: rtl/trig_ep_pkg.sv
package trig_ep_pkg;
   localparam int WORD_W   = 64;
   localparam int TYPE_LSB = 0;
   localparam int TYPE_W   = 4;
   localparam int NUM_LSB  = 16;
   localparam int NUM_W    = 16;
   localparam int RND_LSB  = 32;
   localparam int RND_W    = 8;
   localparam int INFO_LSB = 40;
   localparam int INFO_W   = 24;

   typedef struct packed {
      logic [INFO_W-1:0] info;
      logic [RND_W-1:0]  rnd;
      logic [NUM_W-1:0]  num;
      logic [TYPE_W-1:0] ttype;
   } trig_fields_t;
endpackage

// File: rtl/trig_strobe_ctr.sv
module trig_strobe_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_cmp_o
);
   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 1) begin : g_bad_width
      $error("trig_strobe_ctr: CNT_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst || clear_i) cnt_q <= '0;
      else if (strobe_i)  cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o     = cnt_q;
   assign cnt_cmp_o = strobe_i ? cnt_q + CNT_W'(1) : cnt_q;

   // R4
   cnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe_i && !clear_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   // R7
   cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
      clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/trig_pkt_latch.sv
module trig_pkt_latch
   import trig_ep_pkg::*;
#(
   parameter bit CHECK_NUMBER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pkt_valid_i,
   input  logic [WORD_W-1:0] pkt_word_i,
   input  logic [NUM_W-1:0]  cmp_cnt_i,
   input  logic              rel_evt_i,
   output logic              seen_o,
   output trig_fields_t      fields_o,
   output logic              mism_o
);
   logic         seen_q, mism_q, load, mism_d;
   trig_fields_t fields_q, fields_d;
   logic         unused_rsvd;

   assign unused_rsvd = ^pkt_word_i[NUM_LSB-1:TYPE_LSB+TYPE_W];
   assign load        = pkt_valid_i && !seen_q;

   always_comb begin
      fields_d.ttype = pkt_word_i[TYPE_LSB +: TYPE_W];
      fields_d.num   = pkt_word_i[NUM_LSB  +: NUM_W];
      fields_d.rnd   = pkt_word_i[RND_LSB  +: RND_W];
      fields_d.info  = pkt_word_i[INFO_LSB +: INFO_W];
   end

   if (CHECK_NUMBER) begin : g_cmp
      assign mism_d = (fields_d.num != cmp_cnt_i);
   end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = ^cmp_cnt_i;
      assign mism_d     = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q   <= 1'b0;
         mism_q   <= 1'b0;
         fields_q <= '0;
      end else if (load) begin
         seen_q   <= 1'b1;
         mism_q   <= mism_d;
         fields_q <= fields_d;
      end else if (rel_evt_i) begin
         seen_q   <= 1'b0;
         mism_q   <= 1'b0;
      end
   end

   assign seen_o   = seen_q;
   assign fields_o = fields_q;
   assign mism_o   = mism_q;

   // R1
   rise_chk: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid_i && !seen_q) |=> seen_q);
   // R2
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q && !rel_evt_i) |=> (seen_q && $stable(fields_q)));
   // R3
   fall_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q && rel_evt_i) |=> !seen_q);
endmodule

// File: rtl/trig_release_ctl.sv
module trig_release_ctl #(
   parameter int ERR_W    = 32,
   parameter int MISM_BIT = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             seen_i,
   input  logic             mism_i,
   input  logic             user_rel_i,
   input  logic [ERR_W-1:0] user_err_i,
   output logic             rel_evt_o,
   output logic             rel_valid_o,
   output logic [ERR_W-1:0] rel_err_o
);
   logic             rel_valid_q;
   logic [ERR_W-1:0] rel_err_q, mism_vec;

   if (MISM_BIT < 0 || MISM_BIT >= ERR_W) begin : g_bad_bit
      $error("trig_release_ctl: MISM_BIT outside the error pattern");
   end

   assign mism_vec  = ERR_W'(mism_i) << MISM_BIT;
   assign rel_evt_o = seen_i && (user_rel_i || mism_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         rel_valid_q <= 1'b0;
         rel_err_q   <= '0;
      end else begin
         rel_valid_q <= rel_evt_o;
         if (rel_evt_o) rel_err_q <= user_err_i | mism_vec;
      end
   end

   assign rel_valid_o = rel_valid_q;
   assign rel_err_o   = rel_err_q;

   // R3
   pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rel_valid_q |=> !rel_valid_q);
   // R6
   auto_rel_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_i && mism_i) |=> (rel_valid_q && rel_err_q[MISM_BIT]));
endmodule

// File: rtl/trig_endpoint.sv
module trig_endpoint
   import trig_ep_pkg::*;
#(
   parameter int ERR_W        = 32,
   parameter int MISM_BIT     = 0,
   parameter bit CHECK_NUMBER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe_i,
   input  logic              pkt_valid_i,
   input  logic [WORD_W-1:0] pkt_word_i,
   input  logic              cnt_clear_i,
   input  logic              user_release_i,
   input  logic [ERR_W-1:0]  user_err_i,
   output logic              trg_seen_o,
   output logic [TYPE_W-1:0] trg_type_o,
   output logic [NUM_W-1:0]  trg_num_o,
   output logic [RND_W-1:0]  trg_rand_o,
   output logic [INFO_W-1:0] trg_info_o,
   output logic              rel_valid_o,
   output logic [ERR_W-1:0]  rel_err_o,
   output logic [NUM_W-1:0]  strobe_cnt_o,
   output logic              proto_viol_o
);
   localparam int CNT_W = NUM_W;

   logic [CNT_W-1:0] cmp_cnt;
   logic             seen, mism, rel_evt;
   logic             pending_q, viol_q;
   trig_fields_t     fields;

   trig_strobe_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .strobe_i(strobe_i), .clear_i(cnt_clear_i),
      .cnt_o(strobe_cnt_o), .cnt_cmp_o(cmp_cnt)
   );

   trig_pkt_latch #(.CHECK_NUMBER(CHECK_NUMBER)) u_latch (
      .clk(clk), .rst(rst), .pkt_valid_i(pkt_valid_i), .pkt_word_i(pkt_word_i),
      .cmp_cnt_i(cmp_cnt), .rel_evt_i(rel_evt), .seen_o(seen),
      .fields_o(fields), .mism_o(mism)
   );

   trig_release_ctl #(.ERR_W(ERR_W), .MISM_BIT(MISM_BIT)) u_rel (
      .clk(clk), .rst(rst), .seen_i(seen), .mism_i(mism),
      .user_rel_i(user_release_i), .user_err_i(user_err_i),
      .rel_evt_o(rel_evt), .rel_valid_o(rel_valid_o), .rel_err_o(rel_err_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
         viol_q    <= 1'b0;
      end else begin
         if (strobe_i)     pending_q <= 1'b1;
         else if (rel_evt) pending_q <= 1'b0;
         if (strobe_i && pending_q) viol_q <= 1'b1;
      end
   end

   assign trg_seen_o   = seen;
   assign trg_type_o   = fields.ttype;
   assign trg_num_o    = fields.num;
   assign trg_rand_o   = fields.rnd;
   assign trg_info_o   = fields.info;
   assign proto_viol_o = viol_q;

   // R8
   viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      viol_q |=> viol_q);
   // R8
   viol_set_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe_i && pending_q) |=> viol_q);
endmodule

// File: tb/tb_trig_endpoint.sv
module tb_trig_endpoint;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        strobe_i = 1'b0;
   logic        pkt_valid_i = 1'b0;
   logic [63:0] pkt_word_i = '0;
   logic        cnt_clear_i = 1'b0;
   logic        user_release_i = 1'b0;
   logic [31:0] user_err_i = '0;
   logic        trg_seen_o, rel_valid_o, proto_viol_o;
   logic [3:0]  trg_type_o;
   logic [15:0] trg_num_o, strobe_cnt_o;
   logic [7:0]  trg_rand_o;
   logic [23:0] trg_info_o;
   logic [31:0] rel_err_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [15:0] exp_cnt = '0;

   always #10 clk = ~clk;

   trig_endpoint dut (
      .clk(clk), .rst(rst), .strobe_i(strobe_i), .pkt_valid_i(pkt_valid_i),
      .pkt_word_i(pkt_word_i), .cnt_clear_i(cnt_clear_i),
      .user_release_i(user_release_i), .user_err_i(user_err_i),
      .trg_seen_o(trg_seen_o), .trg_type_o(trg_type_o), .trg_num_o(trg_num_o),
      .trg_rand_o(trg_rand_o), .trg_info_o(trg_info_o), .rel_valid_o(rel_valid_o),
      .rel_err_o(rel_err_o), .strobe_cnt_o(strobe_cnt_o), .proto_viol_o(proto_viol_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [63:0] mk(input logic [23:0] inf, input logic [7:0] rnd,
                                      input logic [15:0] num, input logic [3:0] ty);
      return {inf, rnd, num, 12'h000, ty};
   endfunction

   task automatic do_strobe();
      strobe_i = 1'b1; tick(); strobe_i = 1'b0;
      exp_cnt = exp_cnt + 16'd1;
   endtask

   task automatic send_pkt(input logic [63:0] w);
      pkt_valid_i = 1'b1; pkt_word_i = w; tick(); pkt_valid_i = 1'b0;
   endtask

   task automatic user_release(input logic [31:0] e);
      user_err_i = e; user_release_i = 1'b1; tick(); user_release_i = 1'b0;
   endtask

   task automatic t_reset();
      chk(trg_seen_o == 0, "R9 seen", 64'(trg_seen_o), 0);
      chk(rel_valid_o == 0 && rel_err_o == 0, "R9 release", 64'(rel_err_o), 0);
      chk(strobe_cnt_o == 0 && proto_viol_o == 0, "R9 count/viol", 64'(strobe_cnt_o), 0);
      chk({trg_type_o, trg_num_o, trg_rand_o, trg_info_o} == 0, "R9 fields",
          64'({trg_type_o, trg_num_o, trg_rand_o, trg_info_o}), 0);
   endtask

   task automatic t_basic();
      do_strobe();
      chk(strobe_cnt_o == exp_cnt, "R4 increment", 64'(strobe_cnt_o), 64'(exp_cnt));
      send_pkt(mk(24'h123456, 8'hAB, 16'h0001, 4'hE));
      chk(trg_seen_o == 1, "R1 seen rises", 64'(trg_seen_o), 1);
      chk(trg_type_o == 4'hE && trg_num_o == 16'h0001, "R1 type/number",
          64'({trg_type_o, trg_num_o}), 64'h E0001);
      chk(trg_rand_o == 8'hAB && trg_info_o == 24'h123456, "R1 random/info",
          64'({trg_info_o, trg_rand_o}), 64'h123456AB);
      tick(); tick();
      send_pkt(mk(24'h000F00, 8'h11, 16'h0001, 4'h3));
      chk(trg_seen_o == 1 && rel_valid_o == 0, "R5 match keeps trigger", 64'(rel_valid_o), 0);
      chk({trg_info_o, trg_rand_o, trg_num_o, trg_type_o} == 52'h123456AB0001E, "R2 fields held",
          64'({trg_info_o, trg_rand_o, trg_num_o, trg_type_o}), 64'h123456AB0001E);
      user_release(32'hA5A50000);
      chk(trg_seen_o == 0 && rel_valid_o == 1, "R3 release edge",
          64'({trg_seen_o, rel_valid_o}), 64'b01);
      chk(rel_err_o == 32'hA5A50000, "R3/R5 pattern", 64'(rel_err_o), 64'hA5A50000);
      tick();
      chk(rel_valid_o == 0, "R3 single pulse", 64'(rel_valid_o), 0);
      chk(proto_viol_o == 0, "R8 no violation", 64'(proto_viol_o), 0);
   endtask

   task automatic t_idle_release();
      user_err_i = 32'hFFFF_FFFF; user_release_i = 1'b1; tick(); tick();
      user_release_i = 1'b0;
      chk(rel_valid_o == 0 && trg_seen_o == 0, "R3 idle release ignored", 64'(rel_valid_o), 0);
      chk(rel_err_o == 32'hA5A50000, "R3 idle pattern kept", 64'(rel_err_o), 64'hA5A50000);
      user_err_i = '0;
   endtask

   task automatic t_mismatch();
      do_strobe();
      user_err_i = 32'h0000_0100;
      send_pkt(mk(24'h0, 8'h5A, 16'h0007, 4'h1));
      chk(trg_seen_o == 1 && trg_num_o == 16'h0007, "R1 mismatch word seen", 64'(trg_num_o), 7);
      tick();
      chk(trg_seen_o == 0 && rel_valid_o == 1, "R6 auto release",
          64'({trg_seen_o, rel_valid_o}), 64'b01);
      chk(rel_err_o == 32'h0000_0101, "R5 mismatch bit ORed", 64'(rel_err_o), 64'h101);
      tick();
      chk(rel_valid_o == 0, "R6 single pulse", 64'(rel_valid_o), 0);
      user_err_i = '0;
   endtask

   task automatic t_same_cycle();
      strobe_i = 1'b1; pkt_valid_i = 1'b1;
      pkt_word_i = mk(24'h1, 8'h2, exp_cnt + 16'd1, 4'h4);
      tick();
      strobe_i = 1'b0; pkt_valid_i = 1'b0;
      exp_cnt = exp_cnt + 16'd1;
      chk(trg_seen_o == 1 && strobe_cnt_o == exp_cnt, "R5 same-cycle count",
          64'(strobe_cnt_o), 64'(exp_cnt));
      tick();
      chk(trg_seen_o == 1 && rel_valid_o == 0, "R5 same-cycle match", 64'(rel_valid_o), 0);
      user_release(32'h0000_0002);
      chk(rel_err_o == 32'h2, "R5 bit0 clear on match", 64'(rel_err_o), 2);
      tick();
   endtask

   task automatic t_viol();
      do_strobe();
      do_strobe();
      chk(proto_viol_o == 1, "R8 violation set", 64'(proto_viol_o), 1);
      chk(strobe_cnt_o == exp_cnt, "R8 still counted", 64'(strobe_cnt_o), 64'(exp_cnt));
      send_pkt(mk(24'h0, 8'h0, exp_cnt, 4'h0));
      user_release(32'h0);
      tick();
      chk(proto_viol_o == 1, "R8 sticky", 64'(proto_viol_o), 1);
   endtask

   task automatic t_clear();
      strobe_i = 1'b1; cnt_clear_i = 1'b1; tick();
      strobe_i = 1'b0; cnt_clear_i = 1'b0;
      exp_cnt = '0;
      chk(strobe_cnt_o == 0, "R7 clear wins", 64'(strobe_cnt_o), 0);
   endtask

   task automatic t_wrap();
      strobe_i = 1'b1;
      for (int i = 0; i < 65535; i++) tick();
      chk(strobe_cnt_o == 16'hFFFF, "R4 top value", 64'(strobe_cnt_o), 64'hFFFF);
      tick();
      strobe_i = 1'b0;
      chk(strobe_cnt_o == 16'h0000, "R4 wrap", 64'(strobe_cnt_o), 0);
      send_pkt(mk(24'h0, 8'h0, 16'h0000, 4'h9));
      tick();
      chk(trg_seen_o == 1 && rel_valid_o == 0, "R5 match after wrap", 64'(rel_valid_o), 0);
      user_release(32'h0);
      chk(rel_err_o == 32'h0, "R5 no error after wrap", 64'(rel_err_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      tick(); tick(); tick();
      rst = 1'b0;
      tick();
      t_reset();
      t_basic();
      t_idle_release();
      t_mismatch();
      t_same_cycle();
      t_viol();
      t_clear();
      t_wrap();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule